// File: doc/BRIEF.md
# Tile-Map Coding and Quantizer Selector

This block tells a video compressor, for every 8x8 block it visits, whether the block is to be coded and which of two quantizer table sets applies. Software cuts the frame into 32x32-pixel tiles and stores a two-bit entry per tile in a small bitmap. The quantizer tables themselves are loaded once. Three kinds of frame then come from that one table load: intra frames, inter frames with every block coded, and inter frames where only the marked tiles are coded. Only intra frames and inter frames without motion vectors are in scope.

The compressor presents a block's pixel coordinates and the current frame type on a lookup port. One cycle later the block returns the coded flag, the quantizer set and an out-of-frame flag. Software writes tile entries and a mode register through a plain write port. The bitmap and the mode register are double-buffered. Writes land in a pending copy, and a frame-start pulse swaps that copy into use. A frame can therefore run undisturbed while the next frame's map is being loaded. Frame width and height are parameters and must be multiples of 128 and 64 pixels.

Top module: `tile_qsel`

## Requirements
- R1: After reset, `dec_valid` is low and the live mode is inter-all-coded, so an inter lookup reports coded until a mode write has been swapped in.
- R2: A lookup at pixel (x, y) inside the frame reads tile entry number (y/32)*(FRAME_W/32) + x/32. A tile entry is written at `wr_addr` equal to that number with the top address bit 0. Entry bit 1 is the quantizer set, and it is returned on `dec_qset`.
- R3: For an intra lookup (`lk_intra`=1) inside the frame, `dec_coded` is 1 whatever the entry's bit 0 is.
- R4: For an inter lookup in inter-all-coded mode (mode bit 0 = 0), `dec_coded` is 1.
- R5: For an inter lookup in inter-selected mode (mode bit 0 = 1), `dec_coded` equals the entry's bit 0. The mode register is written at any `wr_addr` whose top bit is 1, with `wr_data[0]` as the mode.
- R6: `dec_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and the other outputs belong to that lookup.
- R7: A tile write does not change lookups until the next `frame_start` pulse, and from that pulse on it does.
- R8: A mode write does not change lookups until the next `frame_start` pulse.
- R9: A tile write in the same cycle as `frame_start` goes to the new pending copy. It becomes visible only at the following pulse.
- R10: A lookup in the same cycle as `frame_start` already uses the map and mode that the pulse brings in.
- R11: A lookup with x >= FRAME_W or y >= FRAME_H returns `dec_oob`=1, `dec_coded`=0 and `dec_qset`=0, even for intra frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that swaps the pending map and mode into use |
| wr_en | input | 1 | Write strobe for tile entries and the mode register |
| wr_addr | input | clog2(tiles)+1 | Tile number, or the mode register when the top bit is 1 |
| wr_data | input | 2 | Bit 1 quantizer set, bit 0 coded; bit 0 is the mode for mode writes |
| lk_valid | input | 1 | Lookup request |
| lk_x | input | COORD_W | Block pixel column |
| lk_y | input | COORD_W | Block pixel row |
| lk_intra | input | 1 | Current frame is intra |
| dec_valid | output | 1 | Result valid |
| dec_coded | output | 1 | Block is coded |
| dec_qset | output | 1 | Quantizer table set select |
| dec_oob | output | 1 | Coordinates fell outside the frame |

## Verification
Every lookup result appears one rising edge after the cycle that presented it. The bench drives a lookup on a falling edge and reads all four outputs on the next falling edge, half a period after the result edge, and it checks `dec_valid` low one falling edge later. Map and mode writes become visible one edge after the `frame_start` pulse that swaps them in. The bench therefore looks up the same tile before and after each pulse, and it also looks up in the pulse cycle itself to pin down the order within that edge.

// File: rtl/tqs_pkg.sv
package tqs_pkg;
  // Tile entry layout: bit 1 quantizer set, bit 0 coded flag.
  typedef struct packed {
    logic qset;
    logic coded;
  } tile_ent_t;

  localparam int TILE_LOG = 5;
endpackage

// File: rtl/tqs_tile_index.sv
module tqs_tile_index #(
  parameter int FRAME_W = 512,
  parameter int FRAME_H = 256,
  parameter int COORD_W = 12,
  parameter int IDX_W   = 7
) (
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  output logic [IDX_W-1:0]   tile_idx,
  output logic               outside
);
  localparam int TILES_X = FRAME_W >> tqs_pkg::TILE_LOG;
  localparam logic [COORD_W-1:0] FW  = COORD_W'(FRAME_W);
  localparam logic [COORD_W-1:0] FH  = COORD_W'(FRAME_H);
  localparam logic [IDX_W-1:0]   TXN = IDX_W'(TILES_X);

  logic [COORD_W-1:0] tx, ty;

  always_comb begin
    tx       = px_x >> tqs_pkg::TILE_LOG;
    ty       = px_y >> tqs_pkg::TILE_LOG;
    tile_idx = IDX_W'(ty) * TXN + IDX_W'(tx);
    outside  = (px_x >= FW) || (px_y >= FH);
  end
endmodule

// File: rtl/tqs_bitmap_ram.sv
module tqs_bitmap_ram #(
  parameter int AW = 8,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port with a registered read: maps to one block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tqs_bank_ctrl.sv
module tqs_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic mode_we,
  input  logic mode_wdata,
  output logic rd_bank,
  output logic wr_bank,
  output logic mode_eff
);
  logic live_bank;
  logic mode_live;
  logic mode_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_bank <= 1'b0;
      mode_live <= 1'b0;
      mode_pend <= 1'b0;
    end else begin
      if (frame_start) begin
        live_bank <= ~live_bank;
        mode_live <= mode_pend;
      end
      if (mode_we) mode_pend <= mode_wdata;
    end
  end

  // A pulse makes the pending copy readable in its own cycle; a write in
  // that cycle already targets the copy that becomes pending.
  always_comb begin
    rd_bank  = live_bank ^ frame_start;
    wr_bank  = ~rd_bank;
    mode_eff = frame_start ? mode_pend : mode_live;
  end
endmodule

// File: rtl/tqs_decide.sv
module tqs_decide
  import tqs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid,
  input  logic      req_intra,
  input  logic      req_outside,
  input  logic      req_selected,
  input  tile_ent_t ent,
  output logic      dec_valid,
  output logic      dec_coded,
  output logic      dec_qset,
  output logic      dec_oob
);
  logic valid_q, intra_q, oob_q, sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      intra_q <= 1'b0;
      oob_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        intra_q <= req_intra;
        oob_q   <= req_outside;
        sel_q   <= req_selected;
      end
    end
  end

  always_comb begin
    dec_valid = valid_q;
    dec_oob   = oob_q;
    dec_coded = !oob_q && (intra_q || !sel_q || ent.coded);
    dec_qset  = !oob_q && ent.qset;
  end
endmodule

// File: rtl/tile_qsel.sv
module tile_qsel
  import tqs_pkg::*;
#(
  parameter int FRAME_W = 512,
  parameter int FRAME_H = 256,
  parameter int COORD_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic wr_en,
  input  logic [$clog2((FRAME_W/32)*(FRAME_H/32)):0] wr_addr,
  input  logic [1:0] wr_data,
  input  logic lk_valid,
  input  logic [COORD_W-1:0] lk_x,
  input  logic [COORD_W-1:0] lk_y,
  input  logic lk_intra,
  output logic dec_valid,
  output logic dec_coded,
  output logic dec_qset,
  output logic dec_oob
);
  localparam int NTILES = (FRAME_W >> TILE_LOG) * (FRAME_H >> TILE_LOG);
  localparam int IDX_W  = $clog2(NTILES);
  localparam int REG_AW = IDX_W + 1;
  localparam logic [IDX_W:0] NT = NTILES[IDX_W:0];

  logic [IDX_W-1:0] rd_idx;
  logic             rd_outside;
  logic             rd_bank, wr_bank, mode_eff;
  logic             tile_we, mode_we;
  tile_ent_t        ent;

  always_comb begin
    mode_we = wr_en && wr_addr[REG_AW-1];
    tile_we = wr_en && !wr_addr[REG_AW-1] && ({1'b0, wr_addr[IDX_W-1:0]} < NT);
  end

  tqs_tile_index #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .COORD_W(COORD_W), .IDX_W(IDX_W)
  ) u_index (
    .px_x(lk_x), .px_y(lk_y), .tile_idx(rd_idx), .outside(rd_outside)
  );

  tqs_bank_ctrl u_bank (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .mode_we(mode_we), .mode_wdata(wr_data[0]),
    .rd_bank(rd_bank), .wr_bank(wr_bank), .mode_eff(mode_eff)
  );

  tqs_bitmap_ram #(.AW(IDX_W + 1), .DW(2)) u_ram (
    .clk(clk),
    .we(tile_we), .waddr({wr_bank, wr_addr[IDX_W-1:0]}), .wdata(wr_data),
    .re(lk_valid), .raddr({rd_bank, rd_idx}), .rdata(ent)
  );

  tqs_decide u_decide (
    .clk(clk), .rst(rst),
    .req_valid(lk_valid), .req_intra(lk_intra), .req_outside(rd_outside),
    .req_selected(mode_eff), .ent(ent),
    .dec_valid(dec_valid), .dec_coded(dec_coded),
    .dec_qset(dec_qset), .dec_oob(dec_oob)
  );
endmodule

// File: rtl/tqs_checker.sv
module tqs_checker #(
  parameter int FRAME_W = 512,
  parameter int FRAME_H = 256,
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic [COORD_W-1:0] lk_x,
  input logic [COORD_W-1:0] lk_y,
  input logic               lk_intra,
  input logic               dec_valid,
  input logic               dec_coded,
  input logic               dec_qset,
  input logic               dec_oob
);
  localparam logic [COORD_W-1:0] FW = COORD_W'(FRAME_W);
  localparam logic [COORD_W-1:0] FH = COORD_W'(FRAME_H);

  // R6
  lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> dec_valid);

  // R6
  lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !dec_valid);

  // R3
  intra_coded_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_intra && lk_x < FW && lk_y < FH) |=> (dec_coded && !dec_oob));

  // R11
  oob_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (lk_x >= FW || lk_y >= FH)) |=> (dec_oob && !dec_coded && !dec_qset));
endmodule

bind tile_qsel tqs_checker #(
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .COORD_W(COORD_W)
) u_tqs_checker (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_x(lk_x), .lk_y(lk_y),
  .lk_intra(lk_intra), .dec_valid(dec_valid), .dec_coded(dec_coded),
  .dec_qset(dec_qset), .dec_oob(dec_oob)
);

// File: tb/test_tile_qsel.sv
`timescale 1ns/1ps
module test_tile_qsel;
  localparam int FW = 512;
  localparam int FH = 256;
  localparam int CW = 12;
  localparam int NT = (FW/32)*(FH/32);
  localparam int AW = $clog2(NT) + 1;
  localparam logic [AW-1:0] MODE_ADDR = {1'b1, {(AW-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, wr_en = 1'b0, lk_valid = 1'b0, lk_intra = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [1:0] wr_data = '0;
  logic [CW-1:0] lk_x = '0, lk_y = '0;
  logic dec_valid, dec_coded, dec_qset, dec_oob;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tile_qsel #(.FRAME_W(FW), .FRAME_H(FH), .COORD_W(CW)) i_tile_qsel (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .lk_valid(lk_valid),
    .lk_x(lk_x), .lk_y(lk_y), .lk_intra(lk_intra), .dec_valid(dec_valid),
    .dec_coded(dec_coded), .dec_qset(dec_qset), .dec_oob(dec_oob)
  );

  // {intra, selected-mode, x, y}
  localparam logic [25:0] VEC [12] = '{
    {1'b0, 1'b0, 12'd0,   12'd0},
    {1'b0, 1'b0, 12'd100, 12'd40},
    {1'b1, 1'b0, 12'd511, 12'd255},
    {1'b0, 1'b1, 12'd37,  12'd70},
    {1'b0, 1'b1, 12'd200, 12'd130},
    {1'b1, 1'b1, 12'd480, 12'd250},
    {1'b0, 1'b1, 12'd64,  12'd224},
    {1'b0, 1'b1, 12'd512, 12'd10},
    {1'b1, 1'b1, 12'd5,   12'd256},
    {1'b0, 1'b0, 12'd300, 12'd200},
    {1'b1, 1'b0, 12'd31,  12'd31},
    {1'b0, 1'b1, 12'd32,  12'd32}
  };

  function automatic logic [1:0] pat(input int idx);
    return 2'((idx * 3 + (idx >> 2)) & 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] d, input bit fs);
    wr_en = 1'b1; wr_addr = a; wr_data = d; frame_start = fs;
    @(negedge clk);
    wr_en = 1'b0; frame_start = 1'b0;
  endtask

  task automatic pulse();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic load(input bit set_mode, input bit mode);
    for (int i = 0; i < NT; i++) wr(AW'(i), pat(i), 1'b0);
    if (set_mode) wr(MODE_ADDR, {1'b0, mode}, 1'b0);
    pulse();
  endtask

  task automatic look(input int x, input int y, input bit intra, input bit fs);
    lk_valid = 1'b1; lk_x = CW'(x); lk_y = CW'(y); lk_intra = intra;
    frame_start = fs;
    @(negedge clk);
    lk_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic expect_out(input string req, input bit c, input bit q, input bit o);
    chk(dec_valid == 1'b1, req, dec_valid, 1);
    chk(dec_coded == c, req, dec_coded, c);
    chk(dec_qset == q, req, dec_qset, q);
    chk(dec_oob == o, req, dec_oob, o);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit cur_mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(dec_valid == 1'b0, "R1", dec_valid, 0);
    load(1'b0, 1'b0);                    // no mode write: reset mode rules
    look(0, 0, 1'b0, 1'b0);              // tile 0 entry = 00
    expect_out("R1", 1'b1, 1'b0, 1'b0);
    load(1'b1, 1'b0);                    // both copies now hold pat()
    cur_mode = 1'b0;

    // Table walk: R2, R3, R4, R5, R11
    foreach (VEC[k]) begin
      int x, y, idx;
      bit intra, sel, out, c, q;
      logic [1:0] e;
      intra = VEC[k][25]; sel = VEC[k][24];
      x = int'(VEC[k][23:12]); y = int'(VEC[k][11:0]);
      if (sel != cur_mode) begin
        load(1'b1, sel);
        cur_mode = sel;
      end
      look(x, y, intra, 1'b0);
      out = (x >= FW) || (y >= FH);
      idx = (y / 32) * (FW / 32) + x / 32;
      e = out ? 2'b00 : pat(idx);
      c = !out && (intra || !sel || e[0]);
      q = !out && e[1];
      expect_out(out ? "R11" : (intra ? "R3" : (sel ? "R5" : "R4 R2")), c, q, out);
    end

    // R6: no result without a request
    @(negedge clk);
    chk(dec_valid == 1'b0, "R6", dec_valid, 0);

    // R7: tile write waits for the pulse
    load(1'b1, 1'b1);
    wr(AW'(5), 2'b10, 1'b0);
    look(160, 0, 1'b0, 1'b0);
    expect_out("R7", 1'b0, 1'b0, 1'b0);
    pulse();
    look(160, 0, 1'b0, 1'b0);
    expect_out("R7", 1'b0, 1'b1, 1'b0);

    // R8: mode write waits for the pulse
    wr(MODE_ADDR, 2'b00, 1'b0);
    look(160, 0, 1'b0, 1'b0);
    expect_out("R8", 1'b0, 1'b1, 1'b0);
    pulse();
    look(160, 0, 1'b0, 1'b0);
    expect_out("R8", 1'b1, 1'b0, 1'b0);

    // R9: write coinciding with the pulse lands one frame later
    wr(MODE_ADDR, 2'b01, 1'b0);
    wr(AW'(9), 2'b01, 1'b0);
    pulse();
    look(288, 0, 1'b0, 1'b0);
    expect_out("R9", 1'b1, 1'b0, 1'b0);
    wr(AW'(9), 2'b10, 1'b0);
    wr(AW'(9), 2'b11, 1'b1);
    look(288, 0, 1'b0, 1'b0);
    expect_out("R9", 1'b0, 1'b1, 1'b0);
    pulse();
    look(288, 0, 1'b0, 1'b0);
    expect_out("R9", 1'b1, 1'b1, 1'b0);

    // R10: lookup in the pulse cycle sees the incoming copy
    look(288, 0, 1'b0, 1'b1);
    expect_out("R10", 1'b0, 1'b1, 1'b0);
    look(288, 0, 1'b0, 1'b0);
    expect_out("R10", 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule